// File: doc/BRIEF.md
# FIFO Flag Offset Programming Port

This block keeps the two threshold offsets that a synchronous FIFO's flag logic compares against: the almost-empty offset and the almost-full offset. Each offset is as wide as the FIFO's address, log2 of its depth. The block drives both values continuously to the flag comparators. It gives software or board logic three ways to reach them. Offsets can be shifted in one bit at a time on a serial clock. They can be written as whole words on the write clock. They can be read back on the read clock through the FIFO's data output bus.

Both load paths and the read path use the same fixed order: the almost-empty offset first, then the almost-full offset, then back to the almost-empty offset. One build parameter chooses which load path exists. The serial variant keeps both offsets in one shift chain clocked by the serial clock. The parallel variant keeps them in the write-clock domain under a two-state write pointer (EMPTY_SEL, FULL_SEL).

The read side is a three-state machine:
- FIFO_VIEW: the bus shows the FIFO's own output register.
- JUST_READ: an offset was latched on the last edge.
- HELD: an offset is on the bus and another read is allowed.

Transitions:
- FIFO_VIEW or HELD moves to JUST_READ on a qualifying read.
- JUST_READ moves to HELD while load-select stays low, and ignores any read attempt.
- Any state returns to FIFO_VIEW when load-select is sampled high.

Top module: `flag_offset_regs`

## Requirements
- R1: After reset (rst_n low, asynchronous), both offsets equal 7. Both access pointers select the almost-empty offset. q shows fifo_q.
- R2: In the parallel variant, each rising wclk edge with ld_n = 0 and wen_n = 0 stores din[X-1:0]. The store alternates between the almost-empty offset (first) and the almost-full offset (second). The new value appears on ae_ofs / af_ofs after that edge, and the other offset is unchanged.
- R3: In the parallel variant, a wclk edge with ld_n = 1 or wen_n = 1 changes neither offset.
- R4: In the serial variant, each rising sclk edge with ld_n = 0 and sen_n = 0 shifts si into a 2X-bit chain, least significant bit first. The almost-empty offset is filled first. After X shifts, the first X bits sit in af_ofs. After 2X shifts, ae_ofs holds the first X bits and af_ofs holds the next X bits.
- R5: In the serial variant, an sclk edge with ld_n = 1 or sen_n = 1 changes neither offset.
- R6: A rising rclk edge with ld_n = 0 and ren_n = 0, outside JUST_READ, latches an offset onto q, zero-extended to the bus width. Successive reads alternate: almost-empty, almost-full, almost-empty, and so on.
- R7: A read attempt on the rclk edge right after a read is ignored. q keeps its value and the read pointer does not advance.
- R8: While ld_n stays low and no new read happens, q holds the last offset read. Once an rclk edge samples ld_n = 1, q shows fifo_q combinationally.
- R9: LOAD_SERIAL = 1 builds only the serial path and LOAD_SERIAL = 0 builds only the parallel path. Activity on the other path's inputs leaves the offsets unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock (parallel load) |
| sclk | input | 1 | Serial load clock |
| rclk | input | 1 | Read clock (offset read-back) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_n | input | 1 | Offset access select, active low |
| wen_n | input | 1 | Write enable, active low |
| din | input | DATA_W | Write data bus |
| sen_n | input | 1 | Serial enable, active low |
| si | input | 1 | Serial data in |
| ren_n | input | 1 | Read enable, active low |
| fifo_q | input | DATA_W | FIFO output register contents |
| q | output | DATA_W | Output bus (FIFO data or offset) |
| ae_ofs | output | $clog2(DEPTH) | Almost-empty offset to flag logic |
| af_ofs | output | $clog2(DEPTH) | Almost-full offset to flag logic |

## Verification
The bench builds two copies with DEPTH = 16 and DATA_W = 8, so each offset is 4 bits wide. One copy uses the parallel load path and the other the serial path, and both share every input. With 4-bit offsets, the bench can sweep all 256 pairs of almost-empty and almost-full values through each load path. Every pair is then read back through the full read order, including the blocked back-to-back read and the wrap to the almost-empty offset. Because the inputs are shared, every load on one path is also a stimulus that the other variant must ignore.

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;

    // Pointer selecting which offset the next access touches
    typedef enum logic {
        EMPTY_SEL = 1'b0,
        FULL_SEL  = 1'b1
    } ofs_sel_e;

    // Read-side view of the output bus
    typedef enum logic [1:0] {
        FIFO_VIEW = 2'd0,
        JUST_READ = 2'd1,
        HELD      = 2'd2
    } rd_state_e;

endpackage

// File: rtl/ofs_par_loader.sv
module ofs_par_loader
    import ofs_prog_pkg::*;
#(
    parameter int OFS_W   = 10,
    parameter int RST_OFS = 7
) (
    input  logic             wclk,
    input  logic             rst_n,
    input  logic             ld_n,
    input  logic             wen_n,
    input  logic [OFS_W-1:0] wdata,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs
);
    localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(RST_OFS);

    ofs_sel_e wptr, wptr_nxt;
    logic     wr_fire;

    assign wr_fire = !ld_n && !wen_n;

    always_comb begin
        unique case (wptr)
            EMPTY_SEL: wptr_nxt = wr_fire ? FULL_SEL  : EMPTY_SEL;
            FULL_SEL:  wptr_nxt = wr_fire ? EMPTY_SEL : FULL_SEL;
        endcase
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) wptr <= EMPTY_SEL;
        else        wptr <= wptr_nxt;
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            ae_ofs <= RST_VAL;
            af_ofs <= RST_VAL;
        end else if (wr_fire) begin
            if (wptr == EMPTY_SEL) ae_ofs <= wdata;
            else                   af_ofs <= wdata;
        end
    end

    // R3: no qualifying write, no change
    p_idle_write_r3: assert property (@(posedge wclk) disable iff (!rst_n)
        !(!ld_n && !wen_n) |=> ($stable(ae_ofs) && $stable(af_ofs)));

    // R2: a write aimed at the empty offset leaves the full offset alone
    p_empty_first_r2: assert property (@(posedge wclk) disable iff (!rst_n)
        (!ld_n && !wen_n && wptr == EMPTY_SEL) |=> (ae_ofs == $past(wdata) && $stable(af_ofs)));

    // R2: the following write lands in the full offset
    p_full_second_r2: assert property (@(posedge wclk) disable iff (!rst_n)
        (!ld_n && !wen_n && wptr == FULL_SEL) |=> (af_ofs == $past(wdata) && $stable(ae_ofs)));

endmodule

// File: rtl/ofs_ser_loader.sv
module ofs_ser_loader #(
    parameter int OFS_W   = 10,
    parameter int RST_OFS = 7
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             ld_n,
    input  logic             sen_n,
    input  logic             si,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs
);
    localparam int               CHAIN_W = 2 * OFS_W;
    localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(RST_OFS);

    // chain = {almost-full, almost-empty}; bits enter at the top
    logic [CHAIN_W-1:0] chain;
    logic               sh_fire;

    assign sh_fire = !ld_n && !sen_n;

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n)       chain <= {RST_VAL, RST_VAL};
        else if (sh_fire) chain <= {si, chain[CHAIN_W-1:1]};
    end

    assign ae_ofs = chain[OFS_W-1:0];
    assign af_ofs = chain[CHAIN_W-1:OFS_W];

    // R4: one qualifying edge moves every bit one place toward the empty LSB
    p_shift_step_r4: assert property (@(posedge sclk) disable iff (!rst_n)
        sh_fire |=> (af_ofs[OFS_W-1] == $past(si) &&
                     ae_ofs[OFS_W-1] == $past(af_ofs[0])));

    // R5: no qualifying edge, no change
    p_shift_idle_r5: assert property (@(posedge sclk) disable iff (!rst_n)
        !sh_fire |=> ($stable(ae_ofs) && $stable(af_ofs)));

endmodule

// File: rtl/ofs_rd_port.sv
module ofs_rd_port
    import ofs_prog_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter int OFS_W  = 10
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              ren_n,
    input  logic [OFS_W-1:0]  ae_ofs,
    input  logic [OFS_W-1:0]  af_ofs,
    input  logic [DATA_W-1:0] fifo_q,
    output logic [DATA_W-1:0] q
);
    rd_state_e        state, state_nxt;
    ofs_sel_e         rptr;
    logic [OFS_W-1:0] shown;
    logic             rd_fire;

    assign rd_fire = !ld_n && !ren_n && (state != JUST_READ);

    always_comb begin
        unique case (state)
            FIFO_VIEW, HELD: begin
                if (ld_n)        state_nxt = FIFO_VIEW;
                else if (!ren_n) state_nxt = JUST_READ;
                else             state_nxt = state;
            end
            JUST_READ: state_nxt = ld_n ? FIFO_VIEW : HELD;
            default:   state_nxt = FIFO_VIEW;
        endcase
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) state <= FIFO_VIEW;
        else        state <= state_nxt;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rptr  <= EMPTY_SEL;
            shown <= '0;
        end else if (rd_fire) begin
            shown <= (rptr == EMPTY_SEL) ? ae_ofs : af_ofs;
            rptr  <= (rptr == EMPTY_SEL) ? FULL_SEL : EMPTY_SEL;
        end
    end

    assign q = (state == FIFO_VIEW) ? fifo_q : DATA_W'(shown);

    // R7: the edge after a read neither reloads nor moves the pointer
    p_no_back_to_back_r7: assert property (@(posedge rclk) disable iff (!rst_n)
        (state == JUST_READ) |=> ($stable(shown) && $stable(rptr)));

    // R6: a read from the empty position latches the almost-empty offset
    p_read_order_r6: assert property (@(posedge rclk) disable iff (!rst_n)
        (rd_fire && rptr == EMPTY_SEL) |=> (q == DATA_W'($past(ae_ofs))));

    // R8: load-select released returns the bus to FIFO data
    p_release_r8: assert property (@(posedge rclk) disable iff (!rst_n)
        ld_n |=> (q == fifo_q));

endmodule

// File: rtl/flag_offset_regs.sv
module flag_offset_regs #(
    parameter int DEPTH       = 1024,
    parameter int DATA_W      = 36,
    parameter bit LOAD_SERIAL = 1'b0,
    parameter int RST_OFS     = 7
) (
    input  logic                       wclk,
    input  logic                       sclk,
    input  logic                       rclk,
    input  logic                       rst_n,
    input  logic                       ld_n,
    input  logic                       wen_n,
    input  logic [DATA_W-1:0]          din,
    input  logic                       sen_n,
    input  logic                       si,
    input  logic                       ren_n,
    input  logic [DATA_W-1:0]          fifo_q,
    output logic [DATA_W-1:0]          q,
    output logic [$clog2(DEPTH)-1:0]   ae_ofs,
    output logic [$clog2(DEPTH)-1:0]   af_ofs
);
    localparam int OFS_W = $clog2(DEPTH);

    // Inputs of the path not built (and upper din bits) are absorbed here
    logic path_unused;
    assign path_unused = ^{wclk, sclk, wen_n, sen_n, si, din};

    // R9: exactly one load path is elaborated
    generate
        if (LOAD_SERIAL) begin : g_serial
            ofs_ser_loader #(
                .OFS_W   (OFS_W),
                .RST_OFS (RST_OFS)
            ) ser_i (
                .sclk   (sclk),
                .rst_n  (rst_n),
                .ld_n   (ld_n),
                .sen_n  (sen_n),
                .si     (si),
                .ae_ofs (ae_ofs),
                .af_ofs (af_ofs)
            );
        end else begin : g_parallel
            ofs_par_loader #(
                .OFS_W   (OFS_W),
                .RST_OFS (RST_OFS)
            ) par_i (
                .wclk   (wclk),
                .rst_n  (rst_n),
                .ld_n   (ld_n),
                .wen_n  (wen_n),
                .wdata  (din[OFS_W-1:0]),
                .ae_ofs (ae_ofs),
                .af_ofs (af_ofs)
            );
        end
    endgenerate

    ofs_rd_port #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) rd_i (
        .rclk   (rclk),
        .rst_n  (rst_n),
        .ld_n   (ld_n),
        .ren_n  (ren_n),
        .ae_ofs (ae_ofs),
        .af_ofs (af_ofs),
        .fifo_q (fifo_q),
        .q      (q)
    );

endmodule

// File: tb/flag_offset_regs_tb_top.sv
module flag_offset_regs_tb_top;
    localparam int DEPTH  = 16;
    localparam int DATA_W = 8;
    localparam int W      = 4;

    logic clk = 1'b0;
    logic rst_n;
    logic ld_n, wen_n, sen_n, si, ren_n;
    logic [DATA_W-1:0] din, fifo_q;
    logic [DATA_W-1:0] q_p, q_s;
    logic [W-1:0] ae_p, af_p, ae_s, af_s;

    int errors = 0;
    int checks = 0;
    logic [W-1:0] pe_ae, pe_af, se_ae, se_af;
    logic [W-1:0] hold_ae, hold_af;

    always #10 clk = ~clk;

    flag_offset_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LOAD_SERIAL(1'b0)) dut_i (
        .wclk(clk), .sclk(clk), .rclk(clk), .rst_n(rst_n), .ld_n(ld_n),
        .wen_n(wen_n), .din(din), .sen_n(sen_n), .si(si), .ren_n(ren_n),
        .fifo_q(fifo_q), .q(q_p), .ae_ofs(ae_p), .af_ofs(af_p));

    flag_offset_regs #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LOAD_SERIAL(1'b1)) dut_ser_i (
        .wclk(clk), .sclk(clk), .rclk(clk), .rst_n(rst_n), .ld_n(ld_n),
        .wen_n(wen_n), .din(din), .sen_n(sen_n), .si(si), .ren_n(ren_n),
        .fifo_q(fifo_q), .q(q_s), .ae_ofs(ae_s), .af_ofs(af_s));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #3000000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        rst_n = 1'b0; ld_n = 1'b1; wen_n = 1'b1; sen_n = 1'b1; si = 1'b0;
        ren_n = 1'b1; din = '0; fifo_q = 8'hA5;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset values and bus pass-through
        chk("R1 ae_p", ae_p, 7); chk("R1 af_p", af_p, 7);
        chk("R1 ae_s", ae_s, 7); chk("R1 af_s", af_s, 7);
        chk("R1 q_p", q_p, 8'hA5); chk("R1 q_s", q_s, 8'hA5);
        pe_ae = 7; pe_af = 7; se_ae = 7; se_af = 7;

        // Parallel sweep over every offset pair
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                fifo_q = 8'((a * 16 + b) ^ 8'h5A);
                ld_n = 1'b0; wen_n = 1'b0; din = {4'(b), 4'(a)};
                step();
                chk("R2 first word to ae", ae_p, a);
                chk("R2 af untouched", af_p, pe_af);
                din = {4'(a), 4'(b)};
                step();
                chk("R2 second word to af", af_p, b);
                chk("R2 ae kept", ae_p, a);
                pe_ae = 4'(a); pe_af = 4'(b);
                wen_n = 1'b1; din = ~din;
                step();
                chk("R3 wen_n high ae", ae_p, pe_ae); chk("R3 wen_n high af", af_p, pe_af);
                ld_n = 1'b1; wen_n = 1'b0;
                step();
                chk("R3 ld_n high ae", ae_p, pe_ae); chk("R3 ld_n high af", af_p, pe_af);
                chk("R9 serial ae unchanged", ae_s, se_ae);
                chk("R9 serial af unchanged", af_s, se_af);
                wen_n = 1'b1; ld_n = 1'b0; ren_n = 1'b0;
                step();
                chk("R6 read 1 ae", q_p, pe_ae);
                chk("R6 read 1 ae serial build", q_s, se_ae);
                step();
                chk("R7 back-to-back ignored", q_p, pe_ae);
                step();
                chk("R6 read 2 af", q_p, pe_af);
                ren_n = 1'b1;
                step();
                chk("R8 hold", q_p, pe_af);
                ren_n = 1'b0;
                step();
                chk("R6 wrap to ae", q_p, pe_ae);
                ren_n = 1'b1;
                step();
                ren_n = 1'b0;
                step();
                chk("R6 read 4 af", q_p, pe_af);
                ren_n = 1'b1; ld_n = 1'b1;
                step();
                chk("R8 release to fifo", q_p, fifo_q);
                fifo_q = ~fifo_q;
                #1;
                chk("R8 fifo follows", q_p, fifo_q);
            end
        end

        // Serial sweep over every offset pair
        wen_n = 1'b1; ren_n = 1'b1;
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                ld_n = 1'b0; sen_n = 1'b0;
                for (int i = 0; i < W; i++) begin
                    si = a[i];
                    step();
                    if (i == 1) begin
                        hold_ae = ae_s; hold_af = af_s;
                        sen_n = 1'b1; si = ~si;
                        step();
                        chk("R5 sen_n high ae", ae_s, hold_ae);
                        chk("R5 sen_n high af", af_s, hold_af);
                        sen_n = 1'b0; ld_n = 1'b1;
                        step();
                        chk("R5 ld_n high ae", ae_s, hold_ae);
                        chk("R5 ld_n high af", af_s, hold_af);
                        ld_n = 1'b0;
                    end
                end
                chk("R4 half-way af", af_s, a);
                chk("R4 half-way ae", ae_s, se_af);
                for (int i = 0; i < W; i++) begin
                    si = b[i];
                    step();
                end
                chk("R4 ae loaded", ae_s, a);
                chk("R4 af loaded", af_s, b);
                chk("R9 parallel ae unchanged", ae_p, pe_ae);
                chk("R9 parallel af unchanged", af_p, pe_af);
                se_ae = 4'(a); se_af = 4'(b);
                sen_n = 1'b1; ren_n = 1'b0;
                step();
                chk("R6 serial read ae", q_s, se_ae);
                chk("R6 parallel read ae", q_p, pe_ae);
                ren_n = 1'b1;
                step();
                ren_n = 1'b0;
                step();
                chk("R6 serial read af", q_s, se_af);
                ren_n = 1'b1; ld_n = 1'b1;
                step();
                chk("R8 serial release", q_s, fifo_q);
            end
        end
        summary();
    end
endmodule